// File: doc/BRIEF.md
# Input Change Notification Unit

This block watches a parameterised group of input pins and raises a single interrupt request when any pin that software has enabled changes level. A rise and a fall both count. Each pin also carries its own weak pull-up and weak pull-down requests. The block passes these to the pads, and it forces the pull-up off for any pin driven as a digital output.

While the clock runs, the pins pass through a two-flop synchronizer. Each cycle the block compares the synchronized value with a reference register that captures the previous synchronized value. A mismatch on an enabled pin sets a sticky per-pin pending bit. The bit stays set until software writes a clear mask. The interrupt request is the registered OR of the pending bits.

When the system clock is gated for sleep, the reference freezes. A combinational compare between the raw pins and the frozen reference then drives an asynchronous wake output, so an enabled pin can restart the system.

Top module: `cn_unit`

## Requirements
- R1: A level change on a pin whose enable bit is 0 never sets that pin's pending bit.
- R2: A rising change and a falling change on an enabled pin each set that pin's pending bit.
- R3: `irq` is 1 exactly when at least one pending bit is 1, and it is updated on the same edge as the pending bits.
- R4: A pending bit stays set until a cycle in which the matching bit of `clr_mask` is 1. In that cycle it clears, unless a new change on that pin sets it on the same edge, in which case the set wins.
- R5: `wake` is 1 only while `sleep` is 1. While `sleep` is 1, it follows without any clock edge whether the raw level of an enabled, armed pin differs from its stored reference.
- R6: `pad_pu[i]` equals `pu_en[i] & ~dir_out[i]` and `pad_pd[i]` equals `pd_en[i]`. Both are registered, with one cycle of latency.
- R7: The reference is refreshed on every clock, so a change that happens while a pin is disabled does not set its pending bit after the pin is enabled. A pin also takes part only one cycle after its enable rises.
- R8: After reset, `pend`, `irq`, `pad_pu` and `pad_pd` are all 0.
- R9: A pin change that is stable before rising edge 1 shows in `pend` after rising edge 3 and not after rising edge 2. This is two synchronizer stages plus the compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped during sleep |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N | Raw input pin levels |
| en | input | N | Per-pin change detection enable |
| pu_en | input | N | Per-pin weak pull-up request |
| pd_en | input | N | Per-pin weak pull-down request |
| dir_out | input | N | 1 when the pin is driven as a digital output |
| clr_mask | input | N | One-cycle clear of the selected pending bits |
| sleep | input | 1 | 1 while the system clock is gated |
| pend | output | N | Sticky per-pin pending flags |
| irq | output | 1 | Interrupt request, OR of the pending bits |
| wake | output | 1 | Asynchronous wake request during sleep |
| pad_pu | output | N | Pull-up enable to the pads |
| pad_pd | output | N | Pull-down enable to the pads |

## Verification
The assertions assume that `clr_mask`, `en` and `dir_out` change only between clock edges, and that `sleep` is raised only while the clock still runs and is lowered before the clock restarts. The bench drives every input on the falling edge. It stops the clock only after `sleep` is set and restarts it before releasing `sleep`. Raw pin changes are held for more than two cycles so the synchronizer always captures them.

// File: rtl/cn_pkg.sv
package cn_pkg;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cn_sync.sv
module cn_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end
  assign q = stage[DEPTH-1];
endmodule

// File: rtl/cn_pads.sv
module cn_pads #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pu_en,
  input  logic [W-1:0] pd_en,
  input  logic [W-1:0] dir_out,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_pd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_pu <= '0;
      pad_pd <= '0;
    end else begin
      pad_pu <= pu_en & ~dir_out;
      pad_pd <= pd_en;
    end
  end
endmodule

// File: rtl/cn_detect.sv
module cn_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] pin_raw,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clr_mask,
  input  logic         sleep,
  output logic [W-1:0] pend,
  output logic         irq,
  output logic         wake
);
  logic [W-1:0] ref_q;
  logic [W-1:0] armed_q;
  logic [W-1:0] hit;
  logic [W-1:0] pend_d;

  assign hit    = en & armed_q & (pin_sync ^ ref_q);
  assign pend_d = (pend & ~clr_mask) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      armed_q <= '0;
      pend    <= '0;
      irq     <= 1'b0;
    end else begin
      ref_q   <= pin_sync;
      armed_q <= en;
      pend    <= pend_d;
      irq     <= |pend_d;
    end
  end

  assign wake = sleep & (|(en & armed_q & (pin_raw ^ ref_q)));
endmodule

// File: rtl/cn_unit.sv
module cn_unit #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] en,
  input  logic [N-1:0] pu_en,
  input  logic [N-1:0] pd_en,
  input  logic [N-1:0] dir_out,
  input  logic [N-1:0] clr_mask,
  input  logic         sleep,
  output logic [N-1:0] pend,
  output logic         irq,
  output logic         wake,
  output logic [N-1:0] pad_pu,
  output logic [N-1:0] pad_pd
);
  logic [N-1:0] pin_sync;

  cn_sync #(.W(N), .DEPTH(cn_pkg::SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  cn_detect #(.W(N)) u_det (
    .clk(clk), .rst(rst), .pin_sync(pin_sync), .pin_raw(pin_in),
    .en(en), .clr_mask(clr_mask), .sleep(sleep),
    .pend(pend), .irq(irq), .wake(wake)
  );

  cn_pads #(.W(N)) u_pads (
    .clk(clk), .rst(rst), .pu_en(pu_en), .pd_en(pd_en),
    .dir_out(dir_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );
endmodule

// File: rtl/cn_unit_chk.sv
module cn_unit_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] en,
  input logic [N-1:0] pu_en,
  input logic [N-1:0] dir_out,
  input logic [N-1:0] clr_mask,
  input logic         sleep,
  input logic [N-1:0] pend,
  input logic         irq,
  input logic         wake,
  input logic [N-1:0] pad_pu
);
  // R1: a newly set pending bit must have been enabled on the previous cycle
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == '0));
  // R3
  p_irq_any_r3: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend));
  // R4
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(pend & ~clr_mask)) == $past(pend & ~clr_mask)));
  // R5
  p_wake_sleep_only_r5: assert property (@(posedge clk) disable iff (rst)
    !sleep |-> !wake);
  // R6
  p_pu_off_output_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_pu & $past(dir_out)) == '0));
  // R6
  p_pu_follow_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_pu == $past(pu_en & ~dir_out)));
endmodule

bind cn_unit cn_unit_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pu_en(pu_en), .dir_out(dir_out),
  .clr_mask(clr_mask), .sleep(sleep), .pend(pend), .irq(irq),
  .wake(wake), .pad_pu(pad_pu)
);

// File: tb/cn_unit_test.sv
module cn_unit_test;
  localparam int N = 8;
  logic clk = 1'b0;
  logic run = 1'b1;
  logic rst;
  logic [N-1:0] pin_in, en, pu_en, pd_en, dir_out, clr_mask;
  logic sleep;
  logic [N-1:0] pend, pad_pu, pad_pd;
  logic irq, wake;
  int checks = 0;
  int fails = 0;

  cn_unit #(.N(N)) uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .en(en), .pu_en(pu_en),
    .pd_en(pd_en), .dir_out(dir_out), .clr_mask(clr_mask), .sleep(sleep),
    .pend(pend), .irq(irq), .wake(wake), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  always #10 if (run) clk = ~clk;

  // entry: {pins, enable, expected pend}
  localparam logic [23:0] VEC [5] = '{
    {8'h01, 8'h0F, 8'h01},  // R2 rising
    {8'h00, 8'h0F, 8'h01},  // R2 falling
    {8'hF0, 8'h0F, 8'h00},  // R1 disabled pins
    {8'hF6, 8'hFF, 8'h06},  // R7 earlier change on 7:4 not reported
    {8'h09, 8'h81, 8'h81}   // R1 mixed enables
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; pin_in = 0; en = 0; pu_en = 0; pd_en = 0; dir_out = 0;
    clr_mask = 0; sleep = 0;
    cyc(3);
    rst = 0;
    check("R8 pend", pend, 0);
    check("R8 irq", irq, 0);
    check("R8 pads", {pad_pu, pad_pd}, 0);
    en = 8'h0F;
    cyc(3);
    for (int i = 0; i < 5; i++) begin
      pin_in = VEC[i][23:16];
      en     = VEC[i][15:8];
      cyc(5);
      check("R1/R2/R7 pend", pend, VEC[i][7:0]);
      check("R3 irq", irq, |VEC[i][7:0]);
      clr_mask = 8'hFF;
      cyc(1);
      clr_mask = 0;
      check("R4 cleared", pend, 0);
    end
    // R9 latency and R4 stickiness
    en = 8'hFF;
    pin_in = 8'h19;
    cyc(2);
    check("R9 not yet", pend, 0);
    cyc(1);
    check("R9 set", pend, 8'h10);
    check("R3 irq with latency", irq, 1);
    cyc(4);
    check("R4 still set", pend, 8'h10);
    clr_mask = 8'h01;
    cyc(1);
    clr_mask = 0;
    check("R4 other mask", pend, 8'h10);
    clr_mask = 8'h10;
    cyc(1);
    clr_mask = 0;
    check("R4 own mask", pend, 0);
    check("R3 irq low", irq, 0);
    // R6 pads
    pu_en = 8'hFF; pd_en = 8'h0F; dir_out = 8'hF0;
    cyc(1);
    check("R6 pull-up", pad_pu, 8'h0F);
    check("R6 pull-down", pad_pd, 8'h0F);
    // R5 sleep wake
    en = 8'h02;
    cyc(2);
    check("R5 awake no wake", wake, 0);
    sleep = 1;
    cyc(1);
    run = 0;
    #50;
    check("R5 sleep idle", wake, 0);
    pin_in = 8'h1B;
    #5;
    check("R5 wake async", wake, 1);
    pin_in = 8'h19;
    #5;
    check("R5 wake drop", wake, 0);
    pin_in = 8'h1B;
    #5;
    run = 1;
    cyc(1);
    sleep = 0;
    #1;
    check("R5 released", wake, 0);
    cyc(4);
    check("R2 after wake", pend, 8'h02);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule